// File: doc/BRIEF.md
# Interprocessor Interrupt Dispatch Unit

This block lets software on either of two processors raise an interrupt aimed at the other processor, at itself, or at both at once. It has four independent channels. A single register write names a channel and carries a destination mask, and every processor selected in that mask receives its own copy of the interrupt (direct delivery). For each channel and each processor the block holds a pending flag. Repeated triggers of the same channel toward the same processor merge into one outstanding interrupt until that processor acknowledges it.

Each processor sees its own interrupt request line. It answers with an acknowledge pulse. The block then returns the lowest-numbered deliverable channel for that processor, clears that pending flag and marks the processor as in service. An end-of-interrupt pulse from the processor ends the service period. A per-channel mask register holds back delivery without losing any pending state.

Top module: `ipi_dispatch_unit`

## Requirements
- R1: After reset every pending flag, every channel mask bit, `irq`, `ack_vld` and `ack_chan` are zero.
- R2: A write with `wr_addr` equal to a channel number (0 to 3) sets that channel's pending flag for each processor whose bit is set in `wr_data[1:0]` (bit 0 is processor 0, bit 1 is processor 1). Each selected processor whose service is idle sees `irq` high from the first clock edge at which the write is sampled.
- R3: Several dispatch writes to one channel for one processor before it is acknowledged produce exactly one acknowledge for that channel. A second acknowledge after end-of-interrupt returns nothing.
- R4: When several channels are deliverable to a processor, an acknowledge returns the lowest-numbered one.
- R5: An acknowledge with a deliverable channel pulses `ack_vld` for one cycle, places the channel number on that processor's `ack_chan` field, clears that channel's pending flag for that processor only, and drops that processor's `irq` while it is in service.
- R6: An acknowledge while the processor is already in service, or while nothing is deliverable to it, leaves `ack_vld` low, sets `ack_chan` to zero and changes no pending flag.
- R7: An end-of-interrupt pulse ends the service period. `irq` rises again on the same edge if any deliverable channel is still pending for that processor.
- R8: A dispatch write to the channel in service sets pending again, so one further interrupt follows after end-of-interrupt.
- R9: Writing address 4 loads `wr_data[3:0]` as the channel mask (bit n masks channel n). A masked channel raises no `irq` and is skipped by acknowledge, but its pending flag is kept and delivers once the mask bit is cleared.
- R10: Writes to addresses 5 to 7, and dispatch writes with an all-zero destination mask, change no state.
- R11: The processors are independent. An acknowledge or end-of-interrupt by one processor leaves the other's pending flags, service state and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0..3 dispatch channel, 4 channel mask |
| wr_data | input | 8 | Write data: destination mask or channel mask |
| ack | input | 2 | Per-processor acknowledge pulse |
| eoi | input | 2 | Per-processor end-of-interrupt pulse |
| irq | output | 2 | Per-processor interrupt request, registered |
| ack_vld | output | 2 | Per-processor acknowledge result valid, one-cycle pulse |
| ack_chan | output | 4 | Per-processor channel number, 2 bits each, processor 0 in the low bits |

## Verification
Every result of this block is registered and lands on the same clock edge that samples its cause. `irq` reflects a dispatch write, a mask write, an acknowledge or an end-of-interrupt right after that edge, and `ack_vld`/`ack_chan` appear after the edge that samples the acknowledge. The bench drives each stimulus for exactly one cycle starting at a falling edge. It reads the outputs at the next falling edge, half a cycle after the edge that registered the result. Checks for R6 and R10 read `irq` and the acknowledge result, which are the only ways a changed pending or service state could become visible.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned IPI_NCHAN = 4;
  localparam int unsigned IPI_NPROC = 2;
  localparam int unsigned IPI_AW    = 3;
  localparam int unsigned IPI_DW    = 8;
endpackage

// File: rtl/ipi_regfile.sv
module ipi_regfile #(
  parameter int unsigned NCHAN = 4,
  parameter int unsigned NPROC = 2,
  parameter int unsigned AW    = 3,
  parameter int unsigned DW    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  output logic [NCHAN*NPROC-1:0] set_o,
  output logic [NCHAN-1:0]       mask_q_o,
  output logic [NCHAN-1:0]       mask_d_o
);
  localparam logic [AW-1:0] MASK_ADDR = AW'(NCHAN);

  logic [NCHAN-1:0] mask_q;

  always_comb begin
    for (int c = 0; c < NCHAN; c++) begin
      set_o[c*NPROC +: NPROC] = (wr_en && (wr_addr == AW'(c))) ?
                                wr_data[NPROC-1:0] : '0;
    end
  end

  assign mask_d_o = (wr_en && (wr_addr == MASK_ADDR)) ? wr_data[NCHAN-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d_o;
  end

  assign mask_q_o = mask_q;

  // R9: the mask changes only through a write to its own address
  p_mask_only_by_write_r9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == MASK_ADDR)) |=> $stable(mask_q));
endmodule

// File: rtl/ipi_channel.sv
module ipi_channel #(
  parameter int unsigned NPROC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPROC-1:0] set_i,
  input  logic [NPROC-1:0] clr_i,
  output logic [NPROC-1:0] pend_o
);
  logic [NPROC-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  // R2: a dispatch always lands, even against a same-cycle clear
  p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R3: without a dispatch, pending flags can only fall
  p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (rst)
    (set_i == '0) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/ipi_cpu_port.sv
module ipi_cpu_port #(
  parameter int unsigned NCHAN     = 4,
  parameter int unsigned CW        = 2,
  parameter bit          LOW_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCHAN-1:0] pend_i,
  input  logic [NCHAN-1:0] set_i,
  input  logic [NCHAN-1:0] mask_q_i,
  input  logic [NCHAN-1:0] mask_d_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic [NCHAN-1:0] clr_o,
  output logic             irq_o,
  output logic             ack_vld_o,
  output logic [CW-1:0]    ack_chan_o
);
  logic [NCHAN-1:0] elig;
  logic [CW-1:0]    pick;
  logic             grant;
  logic             ins_q, ins_d;
  logic [NCHAN-1:0] pend_nx;
  logic             irq_q, vld_q;
  logic [CW-1:0]    chan_q;

  assign elig = pend_i & ~mask_q_i;

  generate
    if (LOW_FIRST) begin : g_low
      always_comb begin
        pick = '0;
        for (int c = NCHAN-1; c >= 0; c--) if (elig[c]) pick = CW'(c);
      end
    end else begin : g_high
      always_comb begin
        pick = '0;
        for (int c = 0; c < NCHAN; c++) if (elig[c]) pick = CW'(c);
      end
    end
  endgenerate

  assign grant = ack_i && !ins_q && (|elig);

  always_comb begin
    clr_o = '0;
    if (grant) clr_o[pick] = 1'b1;
  end

  always_comb begin
    if (grant)      ins_d = 1'b1;
    else if (eoi_i) ins_d = 1'b0;
    else            ins_d = ins_q;
  end

  assign pend_nx = (pend_i & ~clr_o) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_q  <= 1'b0;
      irq_q  <= 1'b0;
      vld_q  <= 1'b0;
      chan_q <= '0;
    end else begin
      ins_q <= ins_d;
      irq_q <= (|(pend_nx & ~mask_d_i)) && !ins_d;
      vld_q <= grant;
      if (ack_i) chan_q <= grant ? pick : '0;
    end
  end

  assign irq_o      = irq_q;
  assign ack_vld_o  = vld_q;
  assign ack_chan_o = chan_q;

  // R5: a granted acknowledge opens a service period
  p_ack_enters_service_r5: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> ins_q);

  // R5: no request is raised while in service
  p_irq_low_in_service_r5: assert property (@(posedge clk) disable iff (rst)
    ins_q |-> !irq_q);

  // R6: an acknowledge while in service is refused
  p_refuse_in_service_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_i && ins_q) |=> !vld_q);

  // R7: end-of-interrupt without a new grant closes service
  p_eoi_closes_r7: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !ack_i) |=> !ins_q);

  // R9: masked channels are never cleared
  p_masked_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_o & mask_q_i) == '0);

  // R4: the granted channel was the lowest deliverable one
  p_lowest_first_r4: assert property (@(posedge clk) disable iff (rst)
    (grant && LOW_FIRST) |-> ((elig & ((NCHAN'(1) << pick) - NCHAN'(1))) == '0));
endmodule

// File: rtl/ipi_dispatch_unit.sv
module ipi_dispatch_unit #(
  parameter int unsigned NCHAN = ipi_pkg::IPI_NCHAN,
  parameter int unsigned NPROC = ipi_pkg::IPI_NPROC,
  parameter int unsigned AW    = ipi_pkg::IPI_AW,
  parameter int unsigned DW    = ipi_pkg::IPI_DW,
  parameter int unsigned CW    = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [NPROC-1:0]    ack,
  input  logic [NPROC-1:0]    eoi,
  output logic [NPROC-1:0]    irq,
  output logic [NPROC-1:0]    ack_vld,
  output logic [NPROC*CW-1:0] ack_chan
);
  logic [NCHAN*NPROC-1:0] set_flat;
  logic [NCHAN*NPROC-1:0] pend_flat;
  logic [NCHAN*NPROC-1:0] clr_flat;
  logic [NCHAN-1:0]       mask_q, mask_d;

  logic [NPROC-1:0][NCHAN-1:0] pend_by_cpu;
  logic [NPROC-1:0][NCHAN-1:0] set_by_cpu;
  logic [NPROC-1:0][NCHAN-1:0] clr_by_cpu;

  ipi_regfile #(.NCHAN(NCHAN), .NPROC(NPROC), .AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .set_o    (set_flat),
    .mask_q_o (mask_q),
    .mask_d_o (mask_d)
  );

  always_comb begin
    for (int p = 0; p < NPROC; p++) begin
      for (int c = 0; c < NCHAN; c++) begin
        pend_by_cpu[p][c]      = pend_flat[c*NPROC + p];
        set_by_cpu[p][c]       = set_flat[c*NPROC + p];
        clr_flat[c*NPROC + p]  = clr_by_cpu[p][c];
      end
    end
  end

  generate
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
      ipi_channel #(.NPROC(NPROC)) u_chan (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_flat[c*NPROC +: NPROC]),
        .clr_i  (clr_flat[c*NPROC +: NPROC]),
        .pend_o (pend_flat[c*NPROC +: NPROC])
      );
    end

    for (genvar p = 0; p < NPROC; p++) begin : g_cpu
      ipi_cpu_port #(.NCHAN(NCHAN), .CW(CW), .LOW_FIRST(1'b1)) u_port (
        .clk        (clk),
        .rst        (rst),
        .pend_i     (pend_by_cpu[p]),
        .set_i      (set_by_cpu[p]),
        .mask_q_i   (mask_q),
        .mask_d_i   (mask_d),
        .ack_i      (ack[p]),
        .eoi_i      (eoi[p]),
        .clr_o      (clr_by_cpu[p]),
        .irq_o      (irq[p]),
        .ack_vld_o  (ack_vld[p]),
        .ack_chan_o (ack_chan[p*CW +: CW])
      );

      // R2: a raised request always has an unmasked pending source
      p_irq_has_source_r2: assert property (@(posedge clk) disable iff (rst)
        irq[p] |-> (|(pend_by_cpu[p] & ~mask_q)));

      // R11: a processor clears only its own pending flags
      p_own_clear_only_r11: assert property (@(posedge clk) disable iff (rst)
        !ack[p] |-> (clr_by_cpu[p] == '0));
    end
  endgenerate
endmodule

// File: tb/ipi_dispatch_unit_test.sv
module ipi_dispatch_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] ack = '0;
  logic [1:0] eoi = '0;
  logic [1:0] irq;
  logic [1:0] ack_vld;
  logic [3:0] ack_chan;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ipi_dispatch_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack(ack), .eoi(eoi), .irq(irq), .ack_vld(ack_vld), .ack_chan(ack_chan)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic reg_write(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ack(input int p);
    @(negedge clk);
    ack[p] = 1'b1;
    @(negedge clk);
    ack[p] = 1'b0;
  endtask

  task automatic do_eoi(input int p);
    @(negedge clk);
    eoi[p] = 1'b1;
    @(negedge clk);
    eoi[p] = 1'b0;
  endtask

  function automatic int chan_of(input int p);
    return int'(ack_chan[p*2 +: 2]);
  endfunction

  task automatic t_reset();
    check("R1 irq", int'(irq), 0);
    check("R1 ack_vld", int'(ack_vld), 0);
    check("R1 ack_chan", int'(ack_chan), 0);
    do_ack(0);
    check("R1 nothing pending", int'(ack_vld), 0);
  endtask

  task automatic t_direct_both();
    reg_write(2, 3);
    check("R2 both irq", int'(irq), 3);
    do_ack(0);
    check("R5 vld p0", int'(ack_vld), 1);
    check("R5 chan p0", chan_of(0), 2);
    check("R11 p1 irq kept", int'(irq), 2);
    do_ack(1);
    check("R11 p1 chan", chan_of(1), 2);
    check("R5 vld p1", int'(ack_vld), 2);
    do_eoi(0);
    do_eoi(1);
    check("R7 idle after eoi", int'(irq), 0);
  endtask

  task automatic t_merge();
    reg_write(1, 1);
    reg_write(1, 1);
    reg_write(1, 1);
    check("R3 irq", int'(irq), 1);
    do_ack(0);
    check("R3 chan", chan_of(0), 1);
    do_eoi(0);
    check("R3 merged irq low", int'(irq), 0);
    do_ack(0);
    check("R3 no second ack", int'(ack_vld), 0);
    check("R6 chan zero", chan_of(0), 0);
  endtask

  task automatic t_priority();
    reg_write(3, 1);
    reg_write(0, 1);
    reg_write(2, 1);
    do_ack(0);
    check("R4 first", chan_of(0), 0);
    do_eoi(0);
    check("R7 reasserts", int'(irq), 1);
    do_ack(0);
    check("R4 second", chan_of(0), 2);
    do_eoi(0);
    do_ack(0);
    check("R4 third", chan_of(0), 3);
    do_eoi(0);
    check("R4 drained", int'(irq), 0);
  endtask

  task automatic t_repend();
    reg_write(1, 2);
    do_ack(1);
    check("R5 p1 chan", chan_of(1), 1);
    check("R5 irq low in service", int'(irq), 0);
    reg_write(1, 2);
    check("R8 held while in service", int'(irq), 0);
    do_ack(1);
    check("R6 refused in service", int'(ack_vld), 0);
    do_eoi(1);
    check("R8 irq after eoi", int'(irq), 2);
    do_ack(1);
    check("R8 second delivery", chan_of(1), 1);
    check("R8 vld", int'(ack_vld), 2);
    do_eoi(1);
    check("R8 drained", int'(irq), 0);
  endtask

  task automatic t_mask();
    reg_write(4, 1);
    reg_write(0, 1);
    check("R9 masked irq", int'(irq), 0);
    do_ack(0);
    check("R9 masked not acked", int'(ack_vld), 0);
    reg_write(3, 1);
    check("R9 other channel irq", int'(irq), 1);
    do_ack(0);
    check("R9 skips masked", chan_of(0), 3);
    do_eoi(0);
    check("R9 still masked", int'(irq), 0);
    reg_write(4, 0);
    check("R9 unmask delivers", int'(irq), 1);
    do_ack(0);
    check("R9 kept pending", chan_of(0), 0);
    do_eoi(0);
    check("R9 drained", int'(irq), 0);
  endtask

  task automatic t_ignore();
    reg_write(5, 255);
    reg_write(6, 255);
    reg_write(7, 255);
    check("R10 bad addr", int'(irq), 0);
    reg_write(2, 0);
    check("R10 empty dest", int'(irq), 0);
    do_ack(0);
    check("R10 nothing pending", int'(ack_vld), 0);
    reg_write(0, 1);
    check("R10 mask unchanged", int'(irq), 1);
    do_ack(0);
    do_eoi(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct_both();
    t_merge();
    t_priority();
    t_repend();
    t_mask();
    t_ignore();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got 0 expected 1");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule